// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block brings an asynchronous DRAM into service after reset and then keeps its contents alive. Once reset is released it waits out a power-up pause, then runs a fixed number of warm-up refresh cycles. After warm-up it raises a ready flag that lets host traffic through, and from then on it owes one refresh per refresh interval. The interval is the refresh period divided by the number of rows.

Every refresh uses CAS-before-RAS ordering, so the memory's own row counter picks the row and the block drives no address. The block shares the strobes with an access controller through a request/grant pair. It needs a grant to begin a cycle. While a cycle runs it flags ownership so that the controller routes this block's strobes to the pins. It holds write-enable high throughout. If grants are late, owed refreshes are counted up to a small limit so that none is lost within that limit.

All timing is given in nanoseconds together with the clock period. The block converts these to clock cycles, rounding up for minimum widths and down for the refresh interval.

Top module: `dram_refresh_init`

## Requirements
- R1: While reset is asserted, ras_n, cas_n and we_n are high, and ref_req, ref_active and ready are low.
- R2: ref_req stays low through the first PAUSE_C-1 clock edges after reset release and is high after edge PAUSE_C, where PAUSE_C = ceil(PAUSE_NS/CLK_NS).
- R3: Exactly WARMUP_N refresh cycles run before ready rises. ready rises on the edge where ref_active falls at the end of the last warm-up cycle, and it never falls afterwards.
- R4: CAS falls only while RAS is high, CSR_C = ceil(T_CSR_NS/CLK_NS) edges before RAS falls. CAS rises CHR_C = ceil(T_CHR_NS/CLK_NS) edges after RAS falls, while RAS is still low.
- R5: RAS stays low for RAS_C = max(ceil(T_RAS_NS/CLK_NS), CHR_C+1) edges. Between cycles RAS stays high for at least PRE_C edges, where PRE_C = max(ceil(T_RP_NS/CLK_NS), ceil(T_RC_NS/CLK_NS)-RAS_C, ceil(T_CRP_NS/CLK_NS)).
- R6: we_n is high at all times.
- R7: A cycle begins only on an edge where ref_req and ref_gnt are both high and no cycle is running. ref_active is high from that edge until precharge ends. ras_n and cas_n are high whenever ref_active is low.
- R8: After ready, one refresh is owed every INT_C = floor(REF_PERIOD_NS/REF_ROWS/CLK_NS) cycles. With grant given at once, consecutive RAS falls are exactly INT_C edges apart.
- R9: The count of owed refreshes saturates at PEND_MAX. If grant is withheld across m interval ticks, then min(m, PEND_MAX) cycles run back to back once grant returns.
- R10: ref_req is high whenever a cycle is running, during warm-up, and whenever at least one refresh is owed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Access controller allows a refresh cycle to begin |
| ref_req | output | 1 | Refresh wanted or in progress |
| ref_active | output | 1 | This block owns the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| ready | output | 1 | Initialisation complete; host traffic allowed |

## Verification
The properties assume that the access controller raises ref_gnt only while ref_req is high. They also assume that the controller treats ref_gnt as meaningful only in cycles where ref_active is low, because a running cycle ignores it. The bench grant model follows these rules: it asserts grant only while a request is pending and no cycle is running. It adds a random delay bounded well below one refresh interval, so that late grants test the backlog without letting more than one tick pile up by accident. Grant is withheld on purpose only in the directed backlog cases, and only after the running cycle has finished.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_CSR,
    CS_RASC,
    CS_RASH,
    CS_PRE
  } cyc_state_t;

  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_WARM,
    PH_RUN
  } phase_t;

  // minimum width in cycles: round up, never below one cycle
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int cyc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // average refresh spacing: round down so the period is never exceeded
  function automatic int interval_cyc(input int period_ns, input int rows, input int clk_ns);
    int c;
    c = (period_ns / rows) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/rfsh_tick_timer.sv
module rfsh_tick_timer #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt;

  assign tick = en && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int PEND_MAX = 4,
  localparam int PW = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          take,
  output logic [PW-1:0] count,
  output logic          owed
);
  assign owed = (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else begin
      case ({tick, take})
        2'b10:   if (count != PW'(PEND_MAX)) count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cbr_cycle_seq.sv
module cbr_cycle_seq
  import dram_rfsh_pkg::*;
#(
  parameter int CSR_C = 1,
  parameter int CHR_C = 2,
  parameter int RAS_C = 8,
  parameter int PRE_C = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic done
);
  localparam int RASH_C = RAS_C - CHR_C;
  localparam int MAXC   = cyc_max(cyc_max(CSR_C, CHR_C), cyc_max(RASH_C, PRE_C));
  localparam int CW     = $clog2(MAXC + 1);

  cyc_state_t   st, st_nx;
  logic [CW-1:0] cnt;
  int           lim;
  logic         last;

  always_comb begin
    case (st)
      CS_CSR:  begin lim = CSR_C;  st_nx = CS_RASC; end
      CS_RASC: begin lim = CHR_C;  st_nx = CS_RASH; end
      CS_RASH: begin lim = RASH_C; st_nx = CS_PRE;  end
      CS_PRE:  begin lim = PRE_C;  st_nx = CS_IDLE; end
      default: begin lim = 1;      st_nx = CS_CSR;  end
    endcase
  end

  assign last = (int'(cnt) == lim - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= CS_IDLE;
      cnt <= '0;
    end else if (st == CS_IDLE) begin
      cnt <= '0;
      if (start) st <= CS_CSR;
    end else if (last) begin
      st  <= st_nx;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ras_n = !((st == CS_RASC) || (st == CS_RASH));
  assign cas_n = !((st == CS_CSR)  || (st == CS_RASC));
  assign busy  = (st != CS_IDLE);
  assign done  = (st == CS_PRE) && last;
endmodule

// File: rtl/dram_refresh_init.sv
module dram_refresh_init
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_NS        = 8,
  parameter int PAUSE_NS      = 200000,
  parameter int WARMUP_N      = 8,
  parameter int REF_ROWS      = 1024,
  parameter int REF_PERIOD_NS = 16000000,
  parameter int T_RAS_NS      = 60,
  parameter int T_RP_NS       = 40,
  parameter int T_RC_NS       = 110,
  parameter int T_CSR_NS      = 5,
  parameter int T_CHR_NS      = 15,
  parameter int T_CRP_NS      = 5,
  parameter int PEND_MAX      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_active,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic ready
);
  localparam int PAUSE_C = ns_to_cyc(PAUSE_NS, CLK_NS);
  localparam int INT_C   = interval_cyc(REF_PERIOD_NS, REF_ROWS, CLK_NS);
  localparam int CSR_C   = ns_to_cyc(T_CSR_NS, CLK_NS);
  localparam int CHR_C   = ns_to_cyc(T_CHR_NS, CLK_NS);
  localparam int RAS_C   = cyc_max(ns_to_cyc(T_RAS_NS, CLK_NS), CHR_C + 1);
  localparam int PRE_C   = cyc_max(cyc_max(ns_to_cyc(T_RP_NS, CLK_NS),
                                           ns_to_cyc(T_RC_NS, CLK_NS) - RAS_C),
                                   ns_to_cyc(T_CRP_NS, CLK_NS));
  localparam int WW      = $clog2(WARMUP_N + 1);
  localparam int PEND_W  = $clog2(PEND_MAX + 1);

  phase_t            phase;
  logic [WW-1:0]     warm_cnt;
  logic              in_pause, in_run;
  logic              pause_tick, int_tick;
  logic              seq_busy, seq_done, seq_start;
  logic              want, owed;
  logic [PEND_W-1:0] pend_cnt;

  assign in_pause = (phase == PH_PAUSE);
  assign in_run   = (phase == PH_RUN);

  rfsh_tick_timer #(.LIMIT(PAUSE_C)) u_pause (
    .clk(clk), .rst_n(rst_n), .en(in_pause), .tick(pause_tick)
  );

  rfsh_tick_timer #(.LIMIT(INT_C)) u_interval (
    .clk(clk), .rst_n(rst_n), .en(in_run), .tick(int_tick)
  );

  rfsh_backlog #(.PEND_MAX(PEND_MAX)) u_backlog (
    .clk(clk), .rst_n(rst_n), .tick(int_tick),
    .take(seq_start && in_run), .count(pend_cnt), .owed(owed)
  );

  assign want      = (phase == PH_WARM) || (in_run && owed);
  assign seq_start = want && ref_gnt && !seq_busy;

  cbr_cycle_seq #(
    .CSR_C(CSR_C), .CHR_C(CHR_C), .RAS_C(RAS_C), .PRE_C(PRE_C)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start),
    .ras_n(ras_n), .cas_n(cas_n), .busy(seq_busy), .done(seq_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_PAUSE;
      warm_cnt <= '0;
    end else begin
      case (phase)
        PH_PAUSE: if (pause_tick) phase <= PH_WARM;
        PH_WARM:  if (seq_done) begin
                    warm_cnt <= warm_cnt + 1'b1;
                    if (warm_cnt == WW'(WARMUP_N - 1)) phase <= PH_RUN;
                  end
        default:  phase <= PH_RUN;
      endcase
    end
  end

  assign ref_req    = want || seq_busy;
  assign ref_active = seq_busy;
  assign we_n       = 1'b1;
  assign ready      = in_run;
endmodule

// File: rtl/dram_refresh_init_chk.sv
module dram_refresh_init_chk #(
  parameter int PEND_MAX = 4,
  parameter int PW       = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          ref_req,
  input logic          ref_gnt,
  input logic          ref_active,
  input logic          ready,
  input logic          in_pause,
  input logic [PW-1:0] pend
);
  assert_no_req_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_pause |-> !ref_req);

  assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  assert_cas_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !cas_n);

  assert_cas_falls_ras_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ras_n);

  assert_start_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_active) |-> $past(ref_gnt && ref_req));

  assert_idle_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_active |-> (ras_n && cas_n));

  assert_backlog_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend) <= PEND_MAX);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_active |-> ref_req);
endmodule

bind dram_refresh_init dram_refresh_init_chk #(
  .PEND_MAX(PEND_MAX), .PW(PEND_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
  .ref_req(ref_req), .ref_gnt(ref_gnt), .ref_active(ref_active),
  .ready(ready), .in_pause(in_pause), .pend(pend_cnt)
);

// File: tb/tb_dram_refresh_init.sv
module tb_dram_refresh_init;
  localparam int CLK_NS   = 8;
  localparam int PAUSE_NS = 2000;
  localparam int PER_NS   = 1638400;
  localparam int ROWS     = 1024;
  localparam int WARM     = 8;
  localparam int PMAX     = 4;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_PAUSE = cdiv(PAUSE_NS, CLK_NS);
  localparam int E_INT   = PER_NS / ROWS / CLK_NS;
  localparam int E_CSR   = cdiv(5, CLK_NS);
  localparam int E_CHR   = cdiv(15, CLK_NS);
  localparam int E_RAS   = imax(cdiv(60, CLK_NS), E_CHR + 1);
  localparam int E_PRE   = imax(imax(cdiv(40, CLK_NS), cdiv(110, CLK_NS) - E_RAS), cdiv(5, CLK_NS));

  logic clk = 0, rst_n = 0, ref_gnt = 0;
  logic ref_req, ref_active, ras_n, cas_n, we_n, ready;

  always #4 clk = ~clk;

  dram_refresh_init #(
    .CLK_NS(CLK_NS), .PAUSE_NS(PAUSE_NS), .WARMUP_N(WARM),
    .REF_ROWS(ROWS), .REF_PERIOD_NS(PER_NS), .PEND_MAX(PMAX)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_active(ref_active), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ready(ready)
  );

  int total = 0, fails = 0;
  int edges = 0;
  int nfall = 0, ndone = 0;
  int ras_fall = 0, ras_rise = 0, cas_fall = 0;
  bit have_rise = 0;
  logic p_ras = 1, p_cas = 1, p_act = 0;
  bit allow = 1;
  int rmax = 0, dly = 0, age = 0;
  logic g_act = 0;
  bit timed_out = 0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) edges <= edges + 1;

  // grant model: only while a request waits and no cycle runs
  always @(negedge clk) begin
    if (!rst_n) begin
      ref_gnt = 0; age = 0;
    end else if (ref_req && !ref_active) begin
      age++;
      ref_gnt = allow && (age > dly);
    end else begin
      age = 0; ref_gnt = 0;
      if (ref_active && !g_act) dly = $urandom_range(rmax, 0);
    end
    g_act = ref_active;
  end

  // strobe timing monitor
  always @(negedge clk) begin
    if (rst_n) begin
      chk(we_n === 1'b1, "R6", we_n, 1);
      if (!ref_active) chk(ras_n && cas_n, "R7", {ras_n, cas_n}, 3);
      if (p_cas && !cas_n) begin
        cas_fall = edges;
        chk(ras_n === 1'b1, "R4", ras_n, 1);
      end
      if (p_ras && !ras_n) begin
        chk(cas_n === 1'b0, "R4", cas_n, 0);
        chk(edges - cas_fall == E_CSR, "R4", edges - cas_fall, E_CSR);
        if (have_rise) chk(edges - ras_rise >= E_PRE, "R5", edges - ras_rise, E_PRE);
        ras_fall = edges;
        nfall++;
      end
      if (!p_cas && cas_n && ras_fall > 0) begin
        chk(!ras_n, "R4", ras_n, 0);
        chk(edges - ras_fall == E_CHR, "R4", edges - ras_fall, E_CHR);
      end
      if (!p_ras && ras_n) begin
        chk(edges - ras_fall == E_RAS, "R5", edges - ras_fall, E_RAS);
        ras_rise = edges; have_rise = 1;
      end
      if (p_act && !ref_active) begin
        ndone++;
        if (ndone == WARM)     chk(ready === 1'b1, "R3", ready, 1);
        if (ndone == WARM - 1) chk(ready === 1'b0, "R3", ready, 0);
      end
      p_ras = ras_n; p_cas = cas_n; p_act = ref_active;
    end
  end

  task automatic wait_edge(input int n);
    while (edges < n) @(negedge clk);
  endtask

  task automatic wait_fall();
    int n0 = nfall;
    while (nfall == n0) @(negedge clk);
  endtask

  task automatic backlog(input int m);
    int t0, n0, n1, exp;
    wait_fall();
    t0 = ras_fall;
    wait_edge(t0 + 20);
    allow = 0;
    n0 = nfall;
    wait_edge(t0 + m * E_INT + 80);
    chk(nfall == n0, "R7", nfall - n0, 0);
    chk(ref_req === 1'b1, "R10", ref_req, 1);
    allow = 1;
    n1 = nfall;
    wait_edge(edges + 110);
    exp = (m < PMAX) ? m : PMAX;
    chk(nfall - n1 == exp, "R9", nfall - n1, exp);
  endtask

  task automatic run_main();
    int t1, n0;
    repeat (5) @(negedge clk);
    chk({ras_n, cas_n, we_n} === 3'b111, "R1", {ras_n, cas_n, we_n}, 7);
    chk({ref_req, ref_active, ready} === 3'b000, "R1", {ref_req, ref_active, ready}, 0);
    rst_n = 1;
    wait_edge(E_PAUSE - 1);
    chk(ref_req === 1'b0, "R2", ref_req, 0);
    wait_edge(E_PAUSE);
    chk(ref_req === 1'b1, "R2", ref_req, 1);
    chk(nfall == 0, "R2", nfall, 0);
    chk(ready === 1'b0, "R3", ready, 0);
    while (!ready) @(negedge clk);
    chk(nfall == WARM, "R3", nfall, WARM);
    // steady spacing, immediate grant
    wait_fall();
    for (int i = 0; i < 3; i++) begin
      t1 = ras_fall;
      wait_fall();
      chk(ras_fall - t1 == E_INT, "R8", ras_fall - t1, E_INT);
    end
    backlog(2);
    backlog(4);
    backlog(6);
    backlog(1);
    // random grant latency
    rmax = 30;
    wait_fall();
    n0 = nfall;
    wait_edge(ras_fall + 20 * E_INT);
    chk((nfall - n0 >= 19) && (nfall - n0 <= 20), "R8", nfall - n0, 20);
    rmax = 0;
    chk(ready === 1'b1, "R3", ready, 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    fork
      run_main();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule